// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the host-facing register front end of a four-channel DMA controller. Each channel keeps a 16-bit base address and a 16-bit word count. The host bus is only 8 bits wide, so every 16-bit register is reached one byte at a time through a small port address space. The port address selects the channel and the register. A single byte pointer selects the low or high byte. It is shared by all channels and both register kinds, and every accepted access moves it on.

Three single-cycle command strobes are also provided. The first returns the byte pointer to the low byte. The second unmasks all channels. The third is a master reset that masks all channels and returns the pointer to the low byte. Reads are registered: read data appears one cycle after the read strobe, together with a one-cycle valid flag. The transfer engine, the request and acknowledge handshake and the page registers sit outside this block.

Top module: `dma_regfile`

## Requirements
- R1: There are four channels, each with a 16-bit address register and a 16-bit count register. An access at port address A targets channel A[2:1]. A[0]=1 selects the count register and A[0]=0 selects the address register. A[3] is ignored, so ports 8..15 alias ports 0..7.
- R2: After any reset of the byte pointer, the first access reaches byte [7:0] and the second reaches byte [15:8]. Accesses alternate between the two from then on. `ptr_hi_o` is 0 when the next access goes to the low byte and 1 when it goes to the high byte.
- R3: The pointer is shared by every channel and register. It toggles on each accepted read or write, whatever the port address, and holds in any cycle with no access and no command.
- R4: A read accepted in cycle N puts the selected byte on `rdata_o` in cycle N+1, with `rvalid_o` high for that one cycle. Reads never change register contents.
- R5: `clr_ff_i` makes the next access a low-byte access. An access in the same cycle still uses the pointer value it found, and the pointer ends at low.
- R6: When `wr_i` and `rd_i` are high in the same cycle, the write is performed and the read is dropped: no `rvalid_o`, and the pointer toggles once.
- R7: `mreset_i` sets all four bits of `mask_o` to 1 and returns the pointer to low. Register contents are left unchanged.
- R8: `clr_mask_i` clears all four bits of `mask_o`. When it arrives in the same cycle as `mreset_i`, the master reset wins and the masks end at 1.
- R9: While `rst_ni` is low, all registers read as zero, `mask_o` is 4'hF, the pointer is low, and `rvalid_o` and `rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Port address |
| wdata_i | input | 8 | Write byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| clr_ff_i | input | 1 | Clear byte pointer command |
| clr_mask_i | input | 1 | Clear all masks command |
| mreset_i | input | 1 | Master reset command |
| rdata_o | output | 8 | Registered read byte |
| rvalid_o | output | 1 | Read byte valid, one cycle |
| mask_o | output | 4 | Per-channel mask bits |
| ptr_hi_o | output | 1 | Next access goes to the high byte |

## Verification
The bench leaves the pointer odd after one access and then reads a different channel. A design with a pointer per channel or per register would return the low byte there instead of the high one. It also pairs each command with an access in the same cycle. If the clear were applied before the access, the byte would land in the wrong half, and a wrong priority between master reset and mask clear would leave the masks at zero. Simultaneous read and write strobes catch a design that toggles the pointer twice or issues a stray valid. The aliased upper ports and a mid-run reset catch decode that uses A[3] and storage that is not cleared.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } byte_half_e;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic [PORT_W-1:0] addr_i,
  output logic [CH_W-1:0]   ch_o,
  output reg_sel_e          sel_o
);
  // upper port bits beyond the channel field are don't-care (aliasing)
  logic unused_hi;
  assign unused_hi = ^addr_i[PORT_W-1:CH_W+1];
  assign ch_o  = addr_i[CH_W:1];
  assign sel_o = reg_sel_e'(addr_i[0]);
endmodule

// File: rtl/dma_rf_byteptr.sv
module dma_rf_byteptr
  import dma_rf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       clear_i,
  output byte_half_e half_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      half_o <= HALF_LO;
    else if (clear_i) half_o <= HALF_LO;
    else if (step_i)  half_o <= byte_half_e'(~half_o);
  end
endmodule

// File: rtl/dma_rf_bank.sv
module dma_rf_bank
  import dma_rf_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   ch_i,
  input  reg_sel_e          sel_i,
  input  byte_half_e        half_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rbyte_o
);
  localparam int unsigned REG_W = 2 * BYTE_W;

  logic [REG_W-1:0] addr_q [NUM_CH];
  logic [REG_W-1:0] cnt_q  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[c] <= '0;
        cnt_q[c]  <= '0;
      end else if (hit) begin
        if (sel_i == SEL_COUNT) begin
          if (half_i == HALF_HI) cnt_q[c][REG_W-1:BYTE_W] <= wdata_i;
          else                   cnt_q[c][BYTE_W-1:0]     <= wdata_i;
        end else begin
          if (half_i == HALF_HI) addr_q[c][REG_W-1:BYTE_W] <= wdata_i;
          else                   addr_q[c][BYTE_W-1:0]     <= wdata_i;
        end
      end
    end
  end

  logic [REG_W-1:0] word;
  always_comb begin
    word    = (sel_i == SEL_COUNT) ? cnt_q[ch_i] : addr_q[ch_i];
    rbyte_o = (half_i == HALF_HI) ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              clr_ff_i,
  input  logic              clr_mask_i,
  input  logic              mreset_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              ptr_hi_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0]   ch;
  reg_sel_e          sel;
  byte_half_e        half;
  logic [BYTE_W-1:0] rbyte;
  logic              rd_acc;

  // write wins over a simultaneous read
  assign rd_acc = rd_i && !wr_i;

  dma_rf_decode #(.PORT_W(PORT_W), .CH_W(CH_W)) i_decode (
    .addr_i (addr_i),
    .ch_o   (ch),
    .sel_o  (sel)
  );

  dma_rf_byteptr i_byteptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (wr_i || rd_acc),
    .clear_i (clr_ff_i || mreset_i),
    .half_o  (half)
  );

  dma_rf_bank #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .CH_W(CH_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_i),
    .ch_i    (ch),
    .sel_i   (sel),
    .half_i  (half),
    .wdata_i (wdata_i),
    .rbyte_o (rbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_o <= '1;
    else if (mreset_i)   mask_o <= '1;
    else if (clr_mask_i) mask_o <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_acc;
      if (rd_acc) rdata_o <= rbyte;
    end
  end

  assign ptr_hi_o = (half == HALF_HI);
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              clr_ff_i,
  input logic              clr_mask_i,
  input logic              mreset_i,
  input logic              rvalid_o,
  input logic [NUM_CH-1:0] mask_o,
  input logic              ptr_hi_o
);
  AST_PTR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && !clr_ff_i && !mreset_i) |=> (ptr_hi_o != $past(ptr_hi_o))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !rd_i && !clr_ff_i && !mreset_i) |=> $stable(ptr_hi_o)); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ff_i || mreset_i) |=> !ptr_hi_o); // R5
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (&mask_o)); // R7
  AST_MASK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask_i && !mreset_i) |=> (mask_o == '0)); // R8
  AST_RD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> rvalid_o); // R4
  AST_RD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !wr_i) |=> !rvalid_o); // R6
endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .clr_ff_i   (clr_ff_i),
  .clr_mask_i (clr_mask_i),
  .mreset_i   (mreset_i),
  .rvalid_o   (rvalid_o),
  .mask_o     (mask_o),
  .ptr_hi_o   (ptr_hi_o)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, clr_ff_i = 1'b0, clr_mask_i = 1'b0, mreset_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rvalid_o;
  logic [3:0] mask_o;
  logic       ptr_hi_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_reg [8];
  logic        m_ptr;
  logic [3:0]  m_mask;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .clr_ff_i(clr_ff_i), .clr_mask_i(clr_mask_i),
    .mreset_i(mreset_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mask_o(mask_o), .ptr_hi_o(ptr_hi_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6: actual unexpected read %h expected no rvalid", rdata_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {8'h0, rdata_o}, {8'h0, e});
      end
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_ptr = 1'b0;
    m_mask = 4'hF;
  endtask

  // drive one cycle (called right after a negedge), update the model, check state
  task automatic op(input logic w, input logic r, input logic c, input logic cm,
                    input logic mr, input logic [3:0] a, input logic [7:0] d,
                    input string tag);
    automatic int idx = int'(a[2:0]);
    wr_i = w; rd_i = r; clr_ff_i = c; clr_mask_i = cm; mreset_i = mr;
    addr_i = a; wdata_i = d;
    if (w) begin
      if (m_ptr) m_reg[idx][15:8] = d;
      else       m_reg[idx][7:0]  = d;
    end else if (r) begin
      exp_q.push_back(m_ptr ? m_reg[idx][15:8] : m_reg[idx][7:0]);
      tag_q.push_back(tag);
    end
    if (w || r) m_ptr = ~m_ptr;
    if (c || mr) m_ptr = 1'b0;
    if (mr) m_mask = 4'hF;
    else if (cm) m_mask = 4'h0;
    @(negedge clk);
    wr_i = 0; rd_i = 0; clr_ff_i = 0; clr_mask_i = 0; mreset_i = 0;
    check({tag, " ptr"}, {15'h0, ptr_hi_o}, {15'h0, m_ptr});
    check({tag, " mask"}, {12'h0, mask_o}, {12'h0, m_mask});
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v, input string tag);
    op(1, 0, 0, 0, 0, a, v[7:0], tag);
    op(1, 0, 0, 0, 0, a, v[15:8], tag);
  endtask

  task automatic rd16(input logic [3:0] a, input string tag);
    op(0, 1, 0, 0, 0, a, 8'h00, tag);
    op(0, 1, 0, 0, 0, a, 8'h00, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 ptr", {15'h0, ptr_hi_o}, 16'h0);
    check("R9 mask", {12'h0, mask_o}, 16'hF);
    check("R9 rvalid", {15'h0, rvalid_o}, 16'h0);
    check("R9 rdata", {8'h0, rdata_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd16(4'd5, "R9 regs zero");

    // R1 R2: fill every register, read all back
    for (int i = 0; i < 8; i++) wr16(4'(i), {4'(i), 4'hC, 8'(i * 37 + 5)}, "R1 write");
    for (int i = 0; i < 8; i++) rd16(4'(i), "R2 readback");
    // R4 repeated reads do not alter contents
    rd16(4'd2, "R4 reread");
    rd16(4'd2, "R4 reread");

    // R1 alias on A[3]
    wr16(4'd11, 16'hBEEF, "R1 alias write");
    rd16(4'd3, "R1 alias read");
    rd16(4'd13, "R1 alias upper");

    // R3 shared pointer across channels
    op(1, 0, 0, 0, 0, 4'd0, 8'h5A, "R3 odd write");
    op(0, 1, 0, 0, 0, 4'd7, 8'h00, "R3 other channel high");
    op(0, 0, 0, 0, 0, 4'd0, 8'h00, "R3 idle hold");

    // R5 clear pointer alone and with an access
    op(0, 1, 0, 0, 0, 4'd4, 8'h00, "R5 setup");
    op(0, 0, 1, 0, 0, 4'd0, 8'h00, "R5 clear");
    op(0, 1, 0, 0, 0, 4'd4, 8'h00, "R5 low after clear");
    op(1, 0, 1, 0, 0, 4'd1, 8'h77, "R5 write with clear");
    rd16(4'd1, "R5 verify");

    // R6 simultaneous read and write
    op(1, 1, 0, 0, 0, 4'd6, 8'h3C, "R6 both");
    op(1, 1, 0, 0, 0, 4'd6, 8'hC3, "R6 both");
    repeat (2) op(0, 0, 0, 0, 0, 4'd0, 8'h00, "R6 idle");
    rd16(4'd6, "R6 verify");

    // R8 clear masks, R7 master reset
    op(0, 0, 0, 1, 0, 4'd0, 8'h00, "R8 clear mask");
    op(1, 0, 0, 0, 0, 4'd2, 8'h99, "R7 odd");
    op(0, 0, 0, 0, 1, 4'd0, 8'h00, "R7 mreset");
    rd16(4'd2, "R7 regs kept");
    op(0, 0, 0, 1, 0, 4'd0, 8'h00, "R8 clear mask again");
    op(0, 0, 0, 1, 1, 4'd0, 8'h00, "R8 mreset wins");

    // R9 mid-run reset clears storage
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    check("R9 mid ptr", {15'h0, ptr_hi_o}, 16'h0);
    check("R9 mid mask", {12'h0, mask_o}, 16'hF);
    rst_ni = 1'b1;
    @(negedge clk);
    rd16(4'd3, "R9 regs cleared");
    rd16(4'd0, "R9 regs cleared");
    repeat (2) @(negedge clk);
    check("R4 scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule